// File: doc/BRIEF.md
# Transmit Frame Assembler

The block collects a transmit frame from a sequence of 32-bit data writes and plays it out as a byte stream. The first word written while the store is empty is a length prefix. Its low 16 bits give the payload length, meaning the bytes after the 14-byte Ethernet header. Every later word carries header and payload bytes, least significant byte first. The store keeps up to 2048 bytes, prefix included.

A frame goes out in one of two ways. The block can launch it by itself once the stored byte count passes a programmable early-start level and the frame is complete. Software can also force it out with a send request. On the way out the two prefix bytes are skipped. Bytes beyond the header plus payload are replaced by zeros, so any software CRC left in the store never reaches the stream. Short frames can be zero-padded to 60 bytes. When the last byte has been taken, the store empties and a transmit-empty flag rises. An illegal length raises an error flag instead. Acknowledging that error also empties the store.

Both streams use valid/ready handshakes. On the write side, `in_ready` is low for the whole time a frame is streaming, and no word is taken then. On the output side, the consumer may hold `out_ready` low for any number of cycles. While it does, `out_data` and `out_last` hold steady.

Top module: `tx_frame_assembler`

## Requirements
- R1: The store holds 2048 bytes. An accepted word lands at byte offsets level..level+3 with bits 7:0 at the lowest offset, and the level grows by 4. A word accepted when fewer than 4 bytes are free is discarded and leaves the contents unchanged.
- R2: When the store is empty, a word whose bits 15:0 exceed 2032 is not stored and sets `tx_err`.
- R3: A frame is complete when the level reaches payload length + 16. Add 4 more when `cfg_crc_auto` is 0. The requirement is capped at 2048.
- R4: When `cfg_thr` is not 63, an accepted word launches the frame if the resulting level is at least 4*(`cfg_thr`*8+1) and the frame is complete. When `cfg_thr` is 63, no launch happens automatically.
- R5: A `send_req` pulse while idle launches the current contents, whatever the threshold.
- R6: The output frame is store bytes 2 onward, payload length + 14 bytes long. Any store byte past that point goes out as 0. With `cfg_pad_en` set and payload length + 14 below 60, the frame is 60 bytes long.
- R7: When fewer than payload length + 14 bytes follow the prefix, only the stored bytes (level − 2) are sent. A launch with an empty store sends nothing and sets `tx_empty` at once.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. `out_last` marks the final byte. `in_ready` is low while a frame streams.
- R9: After the final byte's handshake the store is empty and `tx_empty` is high. `empty_ack` clears it, and a set in the same cycle wins.
- R10: `err_ack` clears `tx_err` and, when idle, empties the store.
- R11: After reset `out_valid`, `tx_err` and `tx_empty` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Word taken this cycle (low while streaming) |
| in_data | input | 32 | Data word, little-endian bytes |
| cfg_pad_en | input | 1 | Pad short frames to 60 bytes |
| cfg_crc_auto | input | 1 | 1: CRC added downstream, no CRC bytes expected in store |
| cfg_thr | input | 6 | Early-start level code, 63 disables |
| send_req | input | 1 | Pulse: launch current contents |
| err_ack | input | 1 | Pulse: clear error and empty store |
| empty_ack | input | 1 | Pulse: clear transmit-empty flag |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of frame |
| tx_err | output | 1 | Illegal length seen |
| tx_empty | output | 1 | Frame fully sent |

## Verification
Each write, send or acknowledge takes effect at the clock edge that accepts it. The bench drives at a falling edge and checks the flags, `in_ready` and `out_valid` at the next falling edge, one cycle later. A launch therefore shows `out_valid` and the first byte in the cycle right after the accepting edge. The bench samples each byte together with its own random `out_ready` choice at a falling edge, and counts the byte only when both were high. `tx_empty` and the emptied store are checked at the falling edge after the final handshake.

// File: rtl/txa_pkg.sv
package txa_pkg;
  localparam int unsigned TXA_BUF_BYTES   = 2048;
  localparam int unsigned TXA_PFX_BYTES   = 2;
  localparam int unsigned TXA_HDR_BYTES   = 14;
  localparam int unsigned TXA_CRC_BYTES   = 4;
  localparam int unsigned TXA_MIN_FRAME   = 60;
  localparam int unsigned TXA_LEN_W       = 16;
  localparam int unsigned TXA_THR_W       = 6;
  localparam int unsigned TXA_THR_WORDS   = 8;
endpackage

// File: rtl/txa_store.sv
module txa_store #(
  parameter int unsigned BUF_BYTES = txa_pkg::TXA_BUF_BYTES,
  parameter int unsigned LVL_W     = $clog2(BUF_BYTES + 1),
  parameter int unsigned RA_W      = $clog2(BUF_BYTES),
  parameter int unsigned LEN_W     = txa_pkg::TXA_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             put,
  input  logic [31:0]      put_data,
  input  logic [RA_W-1:0]  rd_idx,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] level_nxt,
  output logic [LEN_W-1:0] plen_nxt,
  output logic [7:0]       rd_byte
);
  localparam int unsigned WORDS = BUF_BYTES / 4;
  localparam int unsigned AW    = $clog2(WORDS);

  logic [31:0]      mem [WORDS];
  logic [LVL_W-1:0] base;
  logic [LEN_W-1:0] plen_q;
  logic             room;
  logic             wr_go;
  logic [AW-1:0]    waddr;
  logic [31:0]      rword;

  always_comb begin
    base      = clear ? '0 : level;
    room      = ((LVL_W+1)'(base) + (LVL_W+1)'(4)) <= (LVL_W+1)'(BUF_BYTES);
    wr_go     = put && room;
    waddr     = base[AW+1:2];
    level_nxt = wr_go ? base + LVL_W'(4) : base;
    plen_nxt  = (wr_go && base == '0) ? put_data[LEN_W-1:0] : plen_q;
    rword     = mem[rd_idx[AW+1:2]];
    rd_byte   = rword[8*rd_idx[1:0] +: 8];
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[waddr] <= put_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level  <= '0;
      plen_q <= '0;
    end else begin
      level  <= level_nxt;
      plen_q <= plen_nxt;
    end
  end

  // R1: level stays word aligned and inside the store
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= LVL_W'(BUF_BYTES)) && (level[1:0] == 2'b00));
endmodule

// File: rtl/txa_ctrl.sv
module txa_ctrl #(
  parameter int unsigned BUF_BYTES = txa_pkg::TXA_BUF_BYTES,
  parameter int unsigned LVL_W     = $clog2(BUF_BYTES + 1),
  parameter int unsigned LEN_W     = txa_pkg::TXA_LEN_W,
  parameter int unsigned THR_W     = txa_pkg::TXA_THR_W,
  parameter int unsigned PFX_BYTES = txa_pkg::TXA_PFX_BYTES,
  parameter int unsigned HDR_BYTES = txa_pkg::TXA_HDR_BYTES,
  parameter int unsigned CRC_BYTES = txa_pkg::TXA_CRC_BYTES,
  parameter int unsigned MIN_FRAME = txa_pkg::TXA_MIN_FRAME,
  parameter int unsigned THR_WORDS = txa_pkg::TXA_THR_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_fire,
  input  logic [LEN_W-1:0] in_len,
  input  logic             clear,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] level_nxt,
  input  logic [LEN_W-1:0] plen_nxt,
  input  logic             cfg_pad_en,
  input  logic             cfg_crc_auto,
  input  logic [THR_W-1:0] cfg_thr,
  input  logic             send_req,
  input  logic             busy,
  input  logic             last_fire,
  input  logic             err_ack,
  input  logic             empty_ack,
  output logic             too_long,
  output logic             launch,
  output logic [LVL_W-1:0] launch_total,
  output logic [LVL_W-1:0] launch_dend,
  output logic             tx_err,
  output logic             tx_empty
);
  localparam int unsigned MAX_PAYLOAD = BUF_BYTES - PFX_BYTES - HDR_BYTES;
  localparam int unsigned THR_OFF     = (1 << THR_W) - 1;

  logic        start, auto_go, thr_on;
  logic [31:0] lvl32, need, thr_lvl, stored, flen, padded, total;

  always_comb begin
    too_long = in_fire && (clear || level == '0) && (32'(in_len) > MAX_PAYLOAD);
    lvl32    = 32'(level_nxt);
    need     = 32'(plen_nxt) + PFX_BYTES + HDR_BYTES + (cfg_crc_auto ? 32'd0 : CRC_BYTES);
    if (need > BUF_BYTES) need = BUF_BYTES;
    thr_on   = (cfg_thr != THR_W'(THR_OFF));
    thr_lvl  = 32'd4 * (32'(cfg_thr) * THR_WORDS + 32'd1);
    auto_go  = in_fire && thr_on && (lvl32 >= thr_lvl) && (lvl32 >= need);
    start    = !busy && (send_req || auto_go);
    stored   = (lvl32 >= PFX_BYTES) ? lvl32 - PFX_BYTES : 32'd0;
    flen     = 32'(plen_nxt) + HDR_BYTES;
    padded   = (cfg_pad_en && flen < MIN_FRAME) ? MIN_FRAME : flen;
    total    = (stored < flen) ? stored : padded;
    launch       = start && (total != 32'd0);
    launch_total = LVL_W'(total);
    launch_dend  = LVL_W'(flen);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_err   <= 1'b0;
      tx_empty <= 1'b0;
    end else begin
      if (too_long)     tx_err <= 1'b1;
      else if (err_ack) tx_err <= 1'b0;
      if (last_fire || (start && total == 32'd0)) tx_empty <= 1'b1;
      else if (empty_ack)                         tx_empty <= 1'b0;
    end
  end
endmodule

// File: rtl/txa_stream.sv
module txa_stream #(
  parameter int unsigned BUF_BYTES = txa_pkg::TXA_BUF_BYTES,
  parameter int unsigned LVL_W     = $clog2(BUF_BYTES + 1),
  parameter int unsigned RA_W      = $clog2(BUF_BYTES),
  parameter int unsigned PFX_BYTES = txa_pkg::TXA_PFX_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [LVL_W-1:0] launch_total,
  input  logic [LVL_W-1:0] launch_dend,
  input  logic             out_ready,
  input  logic [7:0]       rd_byte,
  output logic [RA_W-1:0]  rd_idx,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             busy,
  output logic             last_fire
);
  logic [LVL_W-1:0] idx_q, total_q, dend_q;

  always_comb begin
    busy      = out_valid;
    rd_idx    = RA_W'(idx_q + LVL_W'(PFX_BYTES));
    out_data  = (idx_q < dend_q) ? rd_byte : 8'h00;
    out_last  = out_valid && (idx_q == total_q - LVL_W'(1));
    last_fire = out_valid && out_ready && out_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      idx_q     <= '0;
      total_q   <= '0;
      dend_q    <= '0;
    end else if (launch) begin
      out_valid <= 1'b1;
      idx_q     <= '0;
      total_q   <= launch_total;
      dend_q    <= launch_dend;
    end else if (out_valid && out_ready) begin
      if (out_last) out_valid <= 1'b0;
      else          idx_q     <= idx_q + LVL_W'(1);
    end
  end

  // R8: stalled byte holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R8: last marker only on a valid byte
  a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

// File: rtl/tx_frame_assembler.sv
module tx_frame_assembler #(
  parameter int unsigned BUF_BYTES = txa_pkg::TXA_BUF_BYTES,
  parameter int unsigned THR_W     = txa_pkg::TXA_THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic             cfg_pad_en,
  input  logic             cfg_crc_auto,
  input  logic [THR_W-1:0] cfg_thr,
  input  logic             send_req,
  input  logic             err_ack,
  input  logic             empty_ack,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             tx_err,
  output logic             tx_empty
);
  localparam int unsigned LVL_W = $clog2(BUF_BYTES + 1);
  localparam int unsigned RA_W  = $clog2(BUF_BYTES);
  localparam int unsigned LEN_W = txa_pkg::TXA_LEN_W;
  localparam int unsigned MAX_PAYLOAD = BUF_BYTES - txa_pkg::TXA_PFX_BYTES - txa_pkg::TXA_HDR_BYTES;

  logic             busy, last_fire, in_fire, clear, put, too_long, launch;
  logic [LVL_W-1:0] level, level_nxt, launch_total, launch_dend;
  logic [LEN_W-1:0] plen_nxt;
  logic [RA_W-1:0]  rd_idx;
  logic [7:0]       rd_byte;

  always_comb begin
    in_ready = !busy;
    in_fire  = in_valid && in_ready;
    clear    = (err_ack && !busy) || last_fire;
    put      = in_fire && !too_long;
  end

  txa_store #(.BUF_BYTES(BUF_BYTES), .LVL_W(LVL_W), .RA_W(RA_W), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(clear), .put(put), .put_data(in_data),
    .rd_idx(rd_idx), .level(level), .level_nxt(level_nxt), .plen_nxt(plen_nxt),
    .rd_byte(rd_byte)
  );

  txa_ctrl #(.BUF_BYTES(BUF_BYTES), .LVL_W(LVL_W), .LEN_W(LEN_W), .THR_W(THR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .in_len(in_data[LEN_W-1:0]),
    .clear(clear), .level(level), .level_nxt(level_nxt), .plen_nxt(plen_nxt),
    .cfg_pad_en(cfg_pad_en), .cfg_crc_auto(cfg_crc_auto), .cfg_thr(cfg_thr),
    .send_req(send_req), .busy(busy), .last_fire(last_fire), .err_ack(err_ack),
    .empty_ack(empty_ack), .too_long(too_long), .launch(launch),
    .launch_total(launch_total), .launch_dend(launch_dend),
    .tx_err(tx_err), .tx_empty(tx_empty)
  );

  txa_stream #(.BUF_BYTES(BUF_BYTES), .LVL_W(LVL_W), .RA_W(RA_W)) u_stream (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_total(launch_total),
    .launch_dend(launch_dend), .out_ready(out_ready), .rd_byte(rd_byte),
    .rd_idx(rd_idx), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .busy(busy), .last_fire(last_fire)
  );

  // R8: store frozen while a frame streams
  a_r8_fifo_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_fire) |=> $stable(level));
  // R9: store empty and flag raised after the final byte
  a_r9_empty_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> (tx_empty && level == '0));
  // R2: oversize length word rejected
  a_r2_reject_long: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && level == '0 && in_data[LEN_W-1:0] > LEN_W'(MAX_PAYLOAD)) |=> (tx_err && level == '0));
  // R4: disabled threshold never launches on a write
  a_r4_thr_off_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && cfg_thr == '1 && !send_req) |=> !busy);
endmodule

// File: tb/tb_tx_frame_assembler.sv
module tb_tx_frame_assembler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        cfg_pad_en = 1'b0;
  logic        cfg_crc_auto = 1'b1;
  logic [5:0]  cfg_thr = 6'd0;
  logic        send_req = 1'b0;
  logic        err_ack = 1'b0;
  logic        empty_ack = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;
  logic        tx_err;
  logic        tx_empty;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  byte unsigned m_mem [2048];
  int m_lvl = 0;
  int m_plen = 0;
  bit m_err = 0;

  always #2 clk = ~clk;

  tx_frame_assembler dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_pad_en(cfg_pad_en), .cfg_crc_auto(cfg_crc_auto), .cfg_thr(cfg_thr),
    .send_req(send_req), .err_ack(err_ack), .empty_ack(empty_ack),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .tx_err(tx_err), .tx_empty(tx_empty)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int need_f();
    int n = m_plen + 16 + (cfg_crc_auto ? 0 : 4);
    return (n > 2048) ? 2048 : n;
  endfunction

  function automatic bit auto_f();
    return (cfg_thr != 6'd63) && (m_lvl >= 4 * (int'(cfg_thr) * 8 + 1)) && (m_lvl >= need_f());
  endfunction

  function automatic int total_f();
    int stored = (m_lvl >= 2) ? m_lvl - 2 : 0;
    int flen = m_plen + 14;
    int padded = (cfg_pad_en && flen < 60) ? 60 : flen;
    return (stored < flen) ? stored : padded;
  endfunction

  // entered and left at a falling edge
  task automatic wr(input logic [31:0] d, output bit st);
    in_valid = 1'b1; in_data = d; st = 1'b0;
    if (m_lvl == 0 && d[15:0] > 16'd2032) m_err = 1'b1;
    else begin
      if (m_lvl + 4 <= 2048) begin
        if (m_lvl == 0) m_plen = int'(d[15:0]);
        for (int b = 0; b < 4; b++) m_mem[m_lvl + b] = d[8*b +: 8];
        m_lvl += 4;
      end
      st = auto_f();
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_pulse();
    send_req = 1'b1;
    @(negedge clk);
    send_req = 1'b0;
  endtask

  task automatic err_pulse();
    err_ack = 1'b1; m_lvl = 0; m_err = 1'b0;
    @(negedge clk);
    err_ack = 1'b0;
  endtask

  task automatic empty_pulse();
    empty_ack = 1'b1;
    @(negedge clk);
    empty_ack = 1'b0;
    chk(tx_empty == 1'b0, "R9", "tx_empty after empty_ack", tx_empty, 0);
  endtask

  task automatic drain(input string tag);
    int tot = total_f();
    int flen = m_plen + 14;
    int got = 0, bad = 0, guard = 0;
    int fk = 0, fa = 0, fe = 0;
    bit seen = 1'b0;
    while (got < tot && guard < 20000) begin
      bit rdy, v, l;
      logic [7:0] d;
      rdy = ($urandom % 4) != 0;
      out_ready = rdy;
      v = out_valid; d = out_data; l = out_last;
      if (v && !seen) begin
        chk(in_ready == 1'b0, "R8", "in_ready while streaming", in_ready, 0);
        seen = 1'b1;
      end
      @(negedge clk);
      guard++;
      if (v && rdy) begin
        int eb = (got < flen) ? int'(m_mem[got + 2]) : 0;
        bit el = (got == tot - 1);
        if (int'(d) != eb || l != el) begin
          if (bad == 0) begin fk = got; fa = int'(d) + 256 * l; fe = eb + 256 * el; end
          bad++;
        end
        got++;
      end
    end
    out_ready = 1'b0;
    chk(bad == 0 && got == tot, "R6", {tag, " frame bytes (idx ", $sformatf("%0d", fk), ")"}, fa, fe);
    chk(tx_empty == 1'b1, "R9", {tag, " tx_empty after last"}, tx_empty, 1);
    chk(out_valid == 1'b0, "R9", {tag, " idle after last"}, out_valid, 0);
    m_lvl = 0;
    empty_pulse();
  endtask

  task automatic run_frame(input int plen, input bit pad, input bit crca, input logic [5:0] thr, input string tag);
    bit st;
    int n = 1;
    int limit;
    cfg_pad_en = pad; cfg_crc_auto = crca; cfg_thr = thr;
    wr({16'($urandom), 16'(plen)}, st);
    limit = need_f() / 4 + 24;
    chk(out_valid == st, "R3", {tag, " launch after first word"}, out_valid, st);
    while (!st && n < limit && m_lvl < 2048) begin
      wr($urandom, st);
      n++;
      chk(out_valid == st, "R4", {tag, " launch on write"}, out_valid, st);
    end
    if (!st) begin
      send_pulse();
      chk(out_valid == (total_f() != 0), "R5", {tag, " launch on send_req"}, out_valid, total_f() != 0);
    end
    drain(tag);
  endtask

  initial begin
    bit st;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
    chk(tx_err == 1'b0, "R11", "tx_err after reset", tx_err, 0);
    chk(tx_empty == 1'b0, "R11", "tx_empty after reset", tx_empty, 0);
    chk(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);

    // R2 oversize length rejected, not stored
    cfg_thr = 6'd0;
    wr(32'h0000_07F1, st);
    chk(tx_err == 1'b1, "R2", "tx_err after length 2033", tx_err, 1);
    chk(out_valid == 1'b0, "R2", "no launch after rejected word", out_valid, 0);
    run_frame(10, 1'b0, 1'b1, 6'd0, "after reject");
    err_pulse();
    chk(tx_err == 1'b0, "R10", "tx_err cleared by err_ack", tx_err, 0);

    // R6 padding with junk CRC bytes in store
    run_frame(5, 1'b1, 1'b0, 6'd0, "pad");

    // R7 truncated send
    cfg_thr = 6'd63; cfg_pad_en = 1'b0; cfg_crc_auto = 1'b1;
    wr(32'h0000_0064, st);
    for (int i = 0; i < 4; i++) wr($urandom, st);
    chk(out_valid == 1'b0, "R4", "threshold off holds frame", out_valid, 0);
    send_pulse();
    chk(out_valid == 1'b1, "R7", "truncated launch", out_valid, 1);
    drain("R7 truncated");

    // R7 empty send
    send_pulse();
    chk(out_valid == 1'b0, "R7", "empty send no data", out_valid, 0);
    chk(tx_empty == 1'b1, "R7", "empty send sets tx_empty", tx_empty, 1);
    empty_pulse();

    // R10 err_ack empties store
    cfg_thr = 6'd63;
    wr(32'h0000_0028, st);
    wr($urandom, st);
    wr($urandom, st);
    err_pulse();
    run_frame(0, 1'b0, 1'b1, 6'd0, "R10 after flush");

    // R1 full store, extra word dropped, 2032 accepted
    cfg_thr = 6'd63; cfg_crc_auto = 1'b0; cfg_pad_en = 1'b0;
    wr(32'h0000_07F0, st);
    for (int i = 1; i < 512; i++) wr($urandom, st);
    chk(tx_err == 1'b0, "R2", "length 2032 accepted", tx_err, 0);
    wr(32'hDEAD_BEEF, st);
    chk(out_valid == 1'b0, "R1", "no launch on dropped word", out_valid, 0);
    send_pulse();
    chk(total_f() == 2046, "R1", "model total full store", total_f(), 2046);
    drain("R1 full");

    // R3 capped requirement with auto start at 2048 bytes
    run_frame(2032, 1'b0, 1'b1, 6'd0, "R3 max");

    // random frames
    for (int f = 0; f < 40; f++) begin
      logic [5:0] thr;
      case ($urandom % 4)
        0: thr = 6'd0;
        1: thr = 6'd1;
        2: thr = 6'd2;
        default: thr = 6'd63;
      endcase
      run_frame(int'($urandom % 90), 1'($urandom), 1'($urandom), thr, "random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule